// File: doc/BRIEF.md
# Programmable ADC Multiplexer Frame Sequencer

This block walks an analog input multiplexer through a repeating frame of conversion slots. The frame holds one to ten slots. Each slot carries two 4-bit channel selects, one for normal frames and one for alternate frames, and both are loaded through a small write port. Slot timing runs off a tick-enable input, one pulse per period of the 32768 Hz base clock. Each slot lasts `SLOT_TICKS` ticks. At the first tick of every slot the block issues a conversion/filter-start strobe. At the last tick of every frame it issues a compute-engine launch strobe.

Software asks for one alternate frame by making a rising edge on a request bit in the control register. The current frame is never cut short. The edge is held in a sticky flag, and the next frame uses the alternate selects. An output flag marks every sample taken in that frame, so that downstream logic can fill in the normal samples the alternate frame displaced.

A battery-monitor channel code is only passed to the converter while its enable bit is set. A reference-chop output toggles once per frame while chopping is enabled.

Top module: `adc_frame_sequencer`

## Requirements
- R1: Control bits [3:0] set the frame length. A value N of 0..9 gives N+1 slots, and any value above 9 gives 10 slots.
- R2: Write addresses 0..9 load the normal select of slots 0..9, and addresses 16..25 load the alternate select of slots 0..9. Each takes bits [3:0] of the write data.
- R3: Every frame begins at slot 0 and steps through the slots in ascending order. `slot_idx` shows the slot in progress and `chan_sel` shows that slot's select for the current frame type.
- R4: A rising edge on control bit [4] leaves the frame in progress unchanged. The next frame, and only that frame, uses the alternate selects with `alt_frame` = 1. The frame after it returns to the normal selects with `alt_frame` = 0.
- R5: A request bit that is set and cleared on consecutive clock cycles is still captured. An edge that arrives during an alternate frame schedules one more alternate frame.
- R6: `conv_start` is high on the first tick of each slot and only then. Each slot spans `SLOT_TICKS` ticks (4 by default).
- R7: `ce_launch` is high exactly once per frame, on the frame's last tick.
- R8: With control bit [6] = 1, `chop` toggles at each frame end. With control bit [6] = 0, `chop` is held low.
- R9: When control bit [5] = 0, a slot whose select is code 4'hB drives `chan_off` = 1 and `chan_sel` = 4'hF. When control bit [5] = 1, the code 4'hB passes through with `chan_off` = 0.
- R10: After reset, `slot_idx` = 0, `alt_frame` = 0, `chop` = 0, and no strobe is issued until a tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per base-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address (0..9 normal, 16..25 alternate, 31 control) |
| wr_data | input | 7 | Register write data |
| chan_sel | output | 4 | Channel code for the current slot |
| chan_off | output | 1 | Selected channel is disabled (battery monitor off) |
| slot_idx | output | 4 | Current slot index |
| alt_frame | output | 1 | Current frame uses alternate selects |
| conv_start | output | 1 | Conversion/filter-start strobe |
| ce_launch | output | 1 | Compute-engine launch strobe |
| chop | output | 1 | Reference-chop level |

## Verification
The hardest case to reach is a request edge that lands while an alternate frame is already running. That frame must finish unchanged, and a second alternate frame must follow it before normal frames resume. The bench gets there by pulsing the request bit for a single cycle on the second tick of a normal frame. It lets the resulting alternate frame begin, then pulses again on that frame's second tick. Four consecutive frames are recorded slot by slot and compared with the normal and alternate tables.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int MAX_SLOTS  = 10;
  localparam int SEL_W      = 4;
  localparam int IDX_W      = $clog2(MAX_SLOTS);
  localparam int ADDR_W     = 5;
  localparam int CTRL_W     = 7;
  localparam int ALT_BASE   = 16;
  localparam int CTRL_ADDR  = 31;
  localparam logic [SEL_W-1:0] BATT_CODE = 4'hB;
  localparam logic [SEL_W-1:0] IDLE_CODE = 4'hF;

  typedef struct packed {
    logic             chop_en;
    logic             batt_en;
    logic             alt_req;
    logic [IDX_W-1:0] len;
  } ctrl_t;
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import seq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CTRL_W-1:0]                 wr_data,
  output logic [MAX_SLOTS-1:0][SEL_W-1:0]   norm_tab,
  output logic [MAX_SLOTS-1:0][SEL_W-1:0]   alt_tab,
  output ctrl_t                             ctrl
);
  logic  ctrl_we;
  ctrl_t ctrl_d;

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
    logic norm_we, alt_we;
    assign norm_we = wr_en && (wr_addr == ADDR_W'(i));
    assign alt_we  = wr_en && (wr_addr == ADDR_W'(ALT_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       norm_tab[i] <= '0;
      else if (norm_we) norm_tab[i] <= wr_data[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      alt_tab[i] <= '0;
      else if (alt_we) alt_tab[i] <= wr_data[SEL_W-1:0];
    end
  end

  assign ctrl_we = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign ctrl_d  = ctrl_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_we) ctrl <= ctrl_d;
  end
endmodule

// File: rtl/seq_alt_latch.sv
module seq_alt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_bit,
  input  logic frame_end,
  output logic pend
);
  logic req_d, edge_seen, pend_d;

  assign edge_seen = req_bit && !req_d;

  always_comb begin
    pend_d = pend;
    if (frame_end) pend_d = 1'b0;
    if (edge_seen) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_d <= req_bit;
      pend  <= pend_d;
    end
  end

  // R5: an edge is captured even if the bit falls on the next cycle
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> pend);
  // R5: the flag stays set until a frame boundary consumes it
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !frame_end) |=> pend);
endmodule

// File: rtl/seq_frame_ctrl.sv
module seq_frame_ctrl
  import seq_pkg::*;
#(
  parameter int SLOT_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [IDX_W-1:0] len,
  input  logic             pend,
  input  logic             chop_en,
  output logic [IDX_W-1:0] slot_q,
  output logic             alt_q,
  output logic             chop_q,
  output logic             conv_start,
  output logic             ce_launch,
  output logic             frame_end
);
  localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);
  localparam logic [IDX_W-1:0]  SLOT_MAX  = IDX_W'(MAX_SLOTS - 1);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [IDX_W-1:0]  slot_d, last_slot;
  logic              alt_d, chop_d, slot_end;

  assign last_slot  = (len > SLOT_MAX) ? SLOT_MAX : len;
  assign slot_end   = tick_en && (tick_q == TICK_LAST);
  assign frame_end  = slot_end && (slot_q >= last_slot);
  assign conv_start = tick_en && (tick_q == '0);
  assign ce_launch  = frame_end;

  always_comb begin
    tick_d = tick_q;
    slot_d = slot_q;
    alt_d  = alt_q;
    if (tick_en) begin
      if (slot_end) begin
        tick_d = '0;
        if (frame_end) begin
          slot_d = '0;
          alt_d  = pend;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!chop_en)       chop_d = 1'b0;
    else if (frame_end) chop_d = !chop_q;
    else                chop_d = chop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
      alt_q  <= 1'b0;
      chop_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      slot_q <= slot_d;
      alt_q  <= alt_d;
      chop_q <= chop_d;
    end
  end

  // R3: a frame boundary returns to slot 0
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (slot_q == '0));
  // R3: inside a frame the slot index steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !frame_end) |=> (slot_q == $past(slot_q) + 1'b1));
  // R4: without a pending request the next frame is normal
  p_one_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !pend) |=> !alt_q);
  // R8: chop held low while disabled
  p_chop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_en |=> !chop_q);
  // R8: chop flips at each frame end while enabled
  p_chop_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_en && frame_end) |=> (chop_q != $past(chop_q)));

  if (SLOT_TICKS > 1) begin : g_gap
    // R6: the start strobe never repeats on back-to-back ticks
    p_conv_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
  end
endmodule

// File: rtl/adc_frame_sequencer.sv
module adc_frame_sequencer
  import seq_pkg::*;
#(
  parameter int SLOT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [SEL_W-1:0]  chan_sel,
  output logic              chan_off,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              alt_frame,
  output logic              conv_start,
  output logic              ce_launch,
  output logic              chop
);
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [MAX_SLOTS-1:0][SEL_W-1:0] norm_tab, alt_tab;
  ctrl_t                           ctrl;
  logic                            pend, frame_end, alt_q;
  logic [IDX_W-1:0]                slot_q;
  logic [SEL_W-1:0]                raw_sel;

  seq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .norm_tab (norm_tab),
    .alt_tab  (alt_tab),
    .ctrl     (ctrl)
  );

  seq_alt_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_bit   (ctrl.alt_req),
    .frame_end (frame_end),
    .pend      (pend)
  );

  seq_frame_ctrl #(.SLOT_TICKS(SLOT_TICKS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_s),
    .tick_en    (tick_en),
    .len        (ctrl.len),
    .pend       (pend),
    .chop_en    (ctrl.chop_en),
    .slot_q     (slot_q),
    .alt_q      (alt_q),
    .chop_q     (chop),
    .conv_start (conv_start),
    .ce_launch  (ce_launch),
    .frame_end  (frame_end)
  );

  assign raw_sel   = alt_q ? alt_tab[slot_q] : norm_tab[slot_q];
  assign chan_off  = (raw_sel == BATT_CODE) && !ctrl.batt_en;
  assign chan_sel  = chan_off ? IDLE_CODE : raw_sel;
  assign slot_idx  = slot_q;
  assign alt_frame = alt_q;

  // R9: the battery code never reaches the converter while disabled
  p_batt_gate_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !ctrl.batt_en |-> (chan_sel != BATT_CODE));
endmodule

// File: tb/sim_adc_frame_sequencer.sv
`timescale 1ns/1ps
module sim_adc_frame_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [3:0] chan_sel, slot_idx;
  logic       chan_off, alt_frame, conv_start, ce_launch, chop;

  always #2.5 clk = ~clk;

  adc_frame_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .chan_sel(chan_sel),
    .chan_off(chan_off), .slot_idx(slot_idx), .alt_frame(alt_frame),
    .conv_start(conv_start), .ce_launch(ce_launch), .chop(chop));

  int total = 0;
  int fails = 0;
  logic [6:0] ctrl_v = '0;

  logic [3:0] g_sel [10];
  logic [3:0] g_idx [10];
  logic       g_off [10];
  logic       g_alt [10];
  int  n_conv, n_ticks, n_launch, bad_gap;
  logic chop_first, chop_any;

  logic s_conv, s_launch, s_off, s_alt, s_chop;
  logic [3:0] s_sel, s_idx;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] alt_val(input int i);
    return 4'((i * 3 + 1) % 16);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [6:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic [6:0] d);
    ctrl_v = d;
    wr(5'd31, d);
  endtask

  task automatic pulse_req();
    @(negedge clk); wr_en = 1'b1; wr_addr = 5'd31; wr_data = ctrl_v | 7'h10;
    @(negedge clk); wr_data = ctrl_v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick_en = 1'b1;
    #1;
    s_conv = conv_start; s_launch = ce_launch; s_sel = chan_sel;
    s_idx = slot_idx; s_off = chan_off; s_alt = alt_frame; s_chop = chop;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic run_frame(input int req_at);
    n_conv = 0; n_ticks = 0; n_launch = 0; bad_gap = 0; chop_any = 1'b0;
    for (int t = 0; t < 200; t++) begin
      do_tick();
      if (t == 0) chop_first = s_chop;
      chop_any = chop_any | s_chop;
      if (s_conv) begin
        if (t != n_conv * 4) bad_gap++;
        if (n_conv < 10) begin
          g_sel[n_conv] = s_sel; g_idx[n_conv] = s_idx;
          g_off[n_conv] = s_off; g_alt[n_conv] = s_alt;
        end
        n_conv++;
      end
      n_ticks++;
      if (s_launch) begin
        n_launch++;
        break;
      end
      if (t == req_at) pulse_req();
    end
  endtask

  task automatic check_frame(input string tag, input int slots, input bit alt);
    check(n_conv == slots, {tag, " R1 slot count"}, n_conv, slots);
    check(n_ticks == slots * 4, {tag, " R7 launch on last tick"}, n_ticks, slots * 4);
    check(bad_gap == 0, {tag, " R6 start strobe spacing"}, bad_gap, 0);
    for (int i = 0; i < slots && i < 10; i++) begin
      logic [3:0] e;
      e = alt ? alt_val(i) : 4'(i);
      check(g_idx[i] == 4'(i), {tag, " R3 slot order"}, g_idx[i], i);
      check(g_sel[i] == e, {tag, " R2 select"}, g_sel[i], e);
      check(g_alt[i] == alt, {tag, " R4 alt flag"}, g_alt[i], alt);
    end
  endtask

  task automatic t_reset();
    #1;
    check(slot_idx == 0, "R10 reset slot", slot_idx, 0);
    check(alt_frame == 0, "R10 reset alt", alt_frame, 0);
    check(chop == 0, "R10 reset chop", chop, 0);
    check(conv_start == 0 && ce_launch == 0, "R10 no strobe", conv_start, 0);
  endtask

  task automatic t_tables();
    for (int i = 0; i < 10; i++) begin
      wr(5'(i), 7'(i));
      wr(5'(16 + i), 7'(alt_val(i)));
    end
    set_ctrl(7'h09);
    run_frame(-1);
    check_frame("full", 10, 1'b0);
  endtask

  task automatic t_lengths();
    set_ctrl(7'h00); run_frame(-1); check_frame("len0", 1, 1'b0);
    set_ctrl(7'h02); run_frame(-1); check_frame("len2", 3, 1'b0);
    set_ctrl(7'h0F); run_frame(-1); check_frame("len15 saturate", 10, 1'b0);
  endtask

  task automatic t_alt();
    set_ctrl(7'h03);
    run_frame(1);  check_frame("R4 req frame", 4, 1'b0);
    run_frame(-1); check_frame("R4 alt frame", 4, 1'b1);
    run_frame(-1); check_frame("R4 back normal", 4, 1'b0);
  endtask

  task automatic t_alt_again();
    set_ctrl(7'h03);
    run_frame(1);  check_frame("R5 first", 4, 1'b0);
    run_frame(1);  check_frame("R5 alt1", 4, 1'b1);
    run_frame(-1); check_frame("R5 alt2", 4, 1'b1);
    run_frame(-1); check_frame("R5 normal", 4, 1'b0);
  endtask

  task automatic t_batt();
    wr(5'd1, 7'h0B);
    set_ctrl(7'h02);
    run_frame(-1);
    check(g_off[1] == 1, "R9 batt off flag", g_off[1], 1);
    check(g_sel[1] == 4'hF, "R9 batt idle code", g_sel[1], 15);
    check(g_off[0] == 0 && g_off[2] == 0, "R9 other slots on", g_off[0], 0);
    set_ctrl(7'h22);
    run_frame(-1);
    check(g_off[1] == 0, "R9 batt enabled flag", g_off[1], 0);
    check(g_sel[1] == 4'hB, "R9 batt passes", g_sel[1], 11);
    wr(5'd1, 7'h01);
  endtask

  task automatic t_chop();
    logic c0, c1, c2;
    set_ctrl(7'h41);
    run_frame(-1); c0 = chop_first;
    run_frame(-1); c1 = chop_first;
    run_frame(-1); c2 = chop_first;
    check(c1 == !c0, "R8 chop toggles 1", c1, !c0);
    check(c2 == !c1, "R8 chop toggles 2", c2, !c1);
    set_ctrl(7'h01);
    run_frame(-1);
    check(chop_any == 0, "R8 chop held low", chop_any, 0);
    run_frame(-1);
    check(chop_any == 0, "R8 chop still low", chop_any, 0);
  endtask

  initial begin
    #500000;
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tables();
    t_lengths();
    t_alt();
    t_alt_again();
    t_batt();
    t_chop();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule